// File: doc/BRIEF.md
# Radix-2 FFT Address Generator

This block is the address sequencer that a small DSP core starts with its transform instruction. Given a source buffer base, a destination buffer base and a size select (8 or 16 complex points), it walks every butterfly of an in-place complex radix-2 decimation-in-time FFT, one butterfly per clock. For each butterfly it drives the data-memory addresses of both operands, with separate real and imaginary addresses for the read side and the write side. It also drives the twiddle index and the stage number. The butterfly arithmetic and the twiddle values belong to the core and are not part of this block.

Complex samples sit interleaved in 16-bit word memory: sample i of a buffer has its real part at base+2i and its imaginary part at base+2i+1. The first stage gathers its inputs from the source buffer in bit-reversed order and writes them into the destination buffer in natural order. Every later stage reads and writes the destination buffer in place. A start is taken only while the block is idle. The block raises busy while butterflies are being issued and gives a one-cycle done pulse once the last one has gone out.

Top module: `fft_addr_gen`

## Requirements
- R1: Out of reset, busy_o and done_o are both 0.
- R2: A start_i seen at a clock edge while idle begins a run: size16_i=0 selects N=8 (3 stages) and size16_i=1 selects N=16 (4 stages). busy_o is 1 from the next cycle for exactly stages*N/2 cycles (12 or 32), with one butterfly presented in each of those cycles.
- R3: Stages run from 0 upward and stage_o shows the current stage s. Within a stage, butterfly k (0..N/2-1) has group g=k>>s and position j=k mod 2^s. Its upper index is p=g*2^(s+1)+j and its lower index is q=p+2^s.
- R4: In stage 0 the read addresses use the source base and the bit-reversed p and q, reversed over log2(N) bits. The write addresses use the destination base and p and q unreversed.
- R5: In stages 1 and above, both the read and the write addresses use the destination base with p and q (in place).
- R6: For index i and base B, the real address is B+2i and the imaginary address is B+2i+1, both taken modulo 2^16.
- R7: twiddle_o is j*(N/2^(s+1)), 3 bits wide. It is 0 throughout stage 0.
- R8: done_o is a single-cycle pulse in the cycle right after the last butterfly, and busy_o is 0 in that cycle. done_o is never 1 at any other time.
- R9: start_i, size16_i and both base inputs have no effect while busy_o is 1. The running sequence keeps the size and bases latched when it was started.
- R10: A start_i held in the done_o cycle is accepted, so a new run follows back to back with busy_o high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| size16_i | input | 1 | 0: 8-point transform, 1: 16-point transform |
| src_base_i | input | 16 | Source buffer base word address |
| dst_base_i | input | 16 | Destination buffer base word address |
| busy_o | output | 1 | Sequence running; the address outputs are valid |
| done_o | output | 1 | One-cycle pulse after the last butterfly |
| stage_o | output | 2 | Current stage number |
| twiddle_o | output | 3 | Twiddle index for the current butterfly |
| rd_a_re_o | output | 16 | Read address, upper operand, real part |
| rd_a_im_o | output | 16 | Read address, upper operand, imaginary part |
| rd_b_re_o | output | 16 | Read address, lower operand, real part |
| rd_b_im_o | output | 16 | Read address, lower operand, imaginary part |
| wr_a_re_o | output | 16 | Write address, upper operand, real part |
| wr_a_im_o | output | 16 | Write address, upper operand, imaginary part |
| wr_b_re_o | output | 16 | Write address, lower operand, real part |
| wr_b_im_o | output | 16 | Write address, lower operand, imaginary part |

## Verification
Both sizes are run with separated source and destination buffers. An error in the stage count, the per-stage group arithmetic or the twiddle scaling only shows in one of the two sizes. A run with a destination base just below 0xFFFF and a source base near the middle forces address wrap-around, which exposes width or carry mistakes in the interleaved mapping. One run toggles start, size and bases while busy, so a restart or a live reread of the inputs breaks the sequence. A back-to-back start in the done cycle, going from 16 points to 8, separates correct re-arming from a lost start or stale latched size.

// File: rtl/fft_ag_pkg.sv
package fft_ag_pkg;

  localparam int unsigned AG_IDX_W = 8;
  typedef logic [AG_IDX_W-1:0] idx_t;

  // Reverse the lowest lg bits of an index.
  function automatic idx_t ag_bit_rev(idx_t i, int unsigned lg);
    idx_t r;
    r = '0;
    for (int unsigned b = 0; b < AG_IDX_W; b++) begin
      if (b < lg) r[lg-1-b] = i[b];
    end
    return r;
  endfunction

  // Position of a butterfly inside its group.
  function automatic idx_t ag_group_pos(idx_t k, int unsigned s);
    idx_t mask;
    mask = (idx_t'(1) << s) - idx_t'(1);
    return k & mask;
  endfunction

  // Upper operand index of butterfly k in stage s.
  function automatic idx_t ag_upper(idx_t k, int unsigned s);
    return ((k >> s) << (s + 1)) | ag_group_pos(k, s);
  endfunction

  // Lower operand index: partner lies 2^s above the upper one.
  function automatic idx_t ag_lower(idx_t k, int unsigned s);
    return ag_upper(k, s) + (idx_t'(1) << s);
  endfunction

  // Twiddle index j * N / 2^(s+1) written as a shift.
  function automatic idx_t ag_twiddle(idx_t k, int unsigned s, int unsigned lg);
    return ag_group_pos(k, s) << (lg - 1 - s);
  endfunction

endpackage

// File: rtl/fft_ag_ctrl.sv
module fft_ag_ctrl #(
  parameter int unsigned LOG_SMALL = 3,
  parameter int unsigned LOG_LARGE = 4,
  localparam int unsigned K_W   = LOG_LARGE - 1,
  localparam int unsigned STG_W = $clog2(LOG_LARGE),
  localparam int unsigned LG_W  = $clog2(LOG_LARGE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             size16_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             last_o,
  output logic [K_W-1:0]   k_o,
  output logic [STG_W-1:0] stage_o,
  output logic [LG_W-1:0]  lg_o
);

  logic             busy_q, done_q;
  logic [K_W-1:0]   k_q;
  logic [STG_W-1:0] stage_q;
  logic [LG_W-1:0]  lg_q;
  logic [K_W-1:0]   k_max_w;
  logic [STG_W-1:0] stage_max_w;
  logic             k_end_w, stage_end_w;

  always_comb begin
    k_max_w     = K_W'((32'd1 << (int'(lg_q) - 1)) - 32'd1);
    stage_max_w = STG_W'(int'(lg_q) - 1);
    k_end_w     = (k_q == k_max_w);
    stage_end_w = (stage_q == stage_max_w);
  end

  assign accept_o = start_i & ~busy_q;
  assign last_o   = busy_q & k_end_w & stage_end_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      k_q     <= '0;
      stage_q <= '0;
      lg_q    <= LG_W'(LOG_SMALL);
    end else begin
      done_q <= last_o;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          k_q     <= '0;
          stage_q <= '0;
          lg_q    <= size16_i ? LG_W'(LOG_LARGE) : LG_W'(LOG_SMALL);
        end
      end else if (k_end_w) begin
        k_q <= '0;
        if (stage_end_w) begin
          busy_q  <= 1'b0;
          stage_q <= '0;
        end else begin
          stage_q <= stage_q + STG_W'(1);
        end
      end else begin
        k_q <= k_q + K_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign k_o     = k_q;
  assign stage_o = stage_q;
  assign lg_o    = lg_q;

endmodule

// File: rtl/fft_ag_index.sv
module fft_ag_index
  import fft_ag_pkg::*;
#(
  parameter int unsigned LOG_LARGE = 4,
  localparam int unsigned IDX_W = LOG_LARGE,
  localparam int unsigned K_W   = LOG_LARGE - 1,
  localparam int unsigned TW_W  = LOG_LARGE - 1,
  localparam int unsigned STG_W = $clog2(LOG_LARGE),
  localparam int unsigned LG_W  = $clog2(LOG_LARGE + 1)
) (
  input  logic [K_W-1:0]   k_i,
  input  logic [STG_W-1:0] stage_i,
  input  logic [LG_W-1:0]  lg_i,
  output logic [IDX_W-1:0] up_o,
  output logic [IDX_W-1:0] lo_o,
  output logic [IDX_W-1:0] up_rev_o,
  output logic [IDX_W-1:0] lo_rev_o,
  output logic [TW_W-1:0]  tw_o
);

  idx_t k_ext, up_full, lo_full, tw_full;

  always_comb begin
    k_ext   = idx_t'(k_i);
    up_full = ag_upper(k_ext, int'(stage_i));
    lo_full = ag_lower(k_ext, int'(stage_i));
    tw_full = ag_twiddle(k_ext, int'(stage_i), int'(lg_i));
    up_o     = IDX_W'(up_full);
    lo_o     = IDX_W'(lo_full);
    up_rev_o = IDX_W'(ag_bit_rev(up_full, int'(lg_i)));
    lo_rev_o = IDX_W'(ag_bit_rev(lo_full, int'(lg_i)));
    tw_o     = TW_W'(tw_full);
  end

endmodule

// File: rtl/fft_ag_addr.sv
module fft_ag_addr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] re_o,
  output logic [ADDR_W-1:0] im_o
);

  logic [ADDR_W-1:0] off_w;

  assign off_w = ADDR_W'({idx_i, 1'b0});
  assign re_o  = base_i + off_w;
  assign im_o  = base_i + off_w + ADDR_W'(1);

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOG_SMALL = 3,
  parameter int unsigned LOG_LARGE = 4,
  localparam int unsigned IDX_W = LOG_LARGE,
  localparam int unsigned K_W   = LOG_LARGE - 1,
  localparam int unsigned TW_W  = LOG_LARGE - 1,
  localparam int unsigned STG_W = $clog2(LOG_LARGE),
  localparam int unsigned LG_W  = $clog2(LOG_LARGE + 1),
  localparam int unsigned LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              size16_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STG_W-1:0]  stage_o,
  output logic [TW_W-1:0]   twiddle_o,
  output logic [ADDR_W-1:0] rd_a_re_o,
  output logic [ADDR_W-1:0] rd_a_im_o,
  output logic [ADDR_W-1:0] rd_b_re_o,
  output logic [ADDR_W-1:0] rd_b_im_o,
  output logic [ADDR_W-1:0] wr_a_re_o,
  output logic [ADDR_W-1:0] wr_a_im_o,
  output logic [ADDR_W-1:0] wr_b_re_o,
  output logic [ADDR_W-1:0] wr_b_im_o
);

  // Named internal events for the checker
  logic              accept_w;
  logic              last_w;
  logic [K_W-1:0]    k_w;
  logic [LG_W-1:0]   lg_w;
  logic              first_stage_w;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [IDX_W-1:0]  up_w, lo_w, up_rev_w, lo_rev_w;

  fft_ag_ctrl #(
    .LOG_SMALL (LOG_SMALL),
    .LOG_LARGE (LOG_LARGE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .size16_i (size16_i),
    .accept_o (accept_w),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .last_o   (last_w),
    .k_o      (k_w),
    .stage_o  (stage_o),
    .lg_o     (lg_w)
  );

  // Bases are captured with the start so the inputs may change during a run
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (accept_w) begin
      src_q <= src_base_i;
      dst_q <= dst_base_i;
    end
  end

  fft_ag_index #(
    .LOG_LARGE (LOG_LARGE)
  ) u_index (
    .k_i      (k_w),
    .stage_i  (stage_o),
    .lg_i     (lg_w),
    .up_o     (up_w),
    .lo_o     (lo_w),
    .up_rev_o (up_rev_w),
    .lo_rev_o (lo_rev_w),
    .tw_o     (twiddle_o)
  );

  assign first_stage_w = (stage_o == '0);

  // Lane 0/1: read upper/lower, lane 2/3: write upper/lower
  logic [ADDR_W-1:0] lane_base [LANES];
  logic [IDX_W-1:0]  lane_idx  [LANES];
  logic [ADDR_W-1:0] lane_re   [LANES];
  logic [ADDR_W-1:0] lane_im   [LANES];

  always_comb begin
    lane_base[0] = first_stage_w ? src_q : dst_q;
    lane_base[1] = first_stage_w ? src_q : dst_q;
    lane_base[2] = dst_q;
    lane_base[3] = dst_q;
    lane_idx[0]  = first_stage_w ? up_rev_w : up_w;
    lane_idx[1]  = first_stage_w ? lo_rev_w : lo_w;
    lane_idx[2]  = up_w;
    lane_idx[3]  = lo_w;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fft_ag_addr #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
    ) u_addr (
      .base_i (lane_base[g]),
      .idx_i  (lane_idx[g]),
      .re_o   (lane_re[g]),
      .im_o   (lane_im[g])
    );
  end

  assign rd_a_re_o = lane_re[0];
  assign rd_a_im_o = lane_im[0];
  assign rd_b_re_o = lane_re[1];
  assign rd_b_im_o = lane_im[1];
  assign wr_a_re_o = lane_re[2];
  assign wr_a_im_o = lane_im[2];
  assign wr_b_re_o = lane_re[3];
  assign wr_b_im_o = lane_im[3];

endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned STG_W  = 2,
  parameter int unsigned TW_W   = 3,
  parameter int unsigned LG_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              last_w,
  input logic [LG_W-1:0]   lg_w,
  input logic [STG_W-1:0]  stage_o,
  input logic [TW_W-1:0]   twiddle_o,
  input logic [ADDR_W-1:0] rd_a_re_o,
  input logic [ADDR_W-1:0] rd_b_re_o,
  input logic [ADDR_W-1:0] rd_b_im_o,
  input logic [ADDR_W-1:0] wr_a_re_o,
  input logic [ADDR_W-1:0] wr_b_re_o
);

  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> (done_o && !busy_o));

  assert_done_only_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_w));

  assert_run_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_w) |=> (busy_o && $stable(lg_w)));

  assert_stage_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (stage_o != $past(stage_o))) |-> (stage_o == $past(stage_o) + STG_W'(1)));

  assert_partner_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((wr_b_re_o - wr_a_re_o) == (ADDR_W'(2) << stage_o)));

  assert_first_twiddle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stage_o == '0) |-> (twiddle_o == '0));

  assert_in_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stage_o != '0) |-> (rd_a_re_o == wr_a_re_o && rd_b_re_o == wr_b_re_o));

  assert_im_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rd_b_im_o == rd_b_re_o + ADDR_W'(1)));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o}));

endmodule

bind fft_addr_gen fft_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .STG_W  (STG_W),
  .TW_W   (TW_W),
  .LG_W   (LG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .last_w    (last_w),
  .lg_w      (lg_w),
  .stage_o   (stage_o),
  .twiddle_o (twiddle_o),
  .rd_a_re_o (rd_a_re_o),
  .rd_b_re_o (rd_b_re_o),
  .rd_b_im_o (rd_b_im_o),
  .wr_a_re_o (wr_a_re_o),
  .wr_b_re_o (wr_b_re_o)
);

// File: tb/fft_addr_gen_tb.sv
module fft_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        size16_i = 1'b0;
  logic [15:0] src_base_i = '0;
  logic [15:0] dst_base_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  stage_o;
  logic [2:0]  twiddle_o;
  logic [15:0] rd_a_re_o, rd_a_im_o, rd_b_re_o, rd_b_im_o;
  logic [15:0] wr_a_re_o, wr_a_im_o, wr_b_re_o, wr_b_im_o;

  always #2 clk = ~clk;

  fft_addr_gen u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .size16_i (size16_i),
    .src_base_i (src_base_i), .dst_base_i (dst_base_i),
    .busy_o (busy_o), .done_o (done_o), .stage_o (stage_o), .twiddle_o (twiddle_o),
    .rd_a_re_o (rd_a_re_o), .rd_a_im_o (rd_a_im_o), .rd_b_re_o (rd_b_re_o), .rd_b_im_o (rd_b_im_o),
    .wr_a_re_o (wr_a_re_o), .wr_a_im_o (wr_a_im_o), .wr_b_re_o (wr_b_re_o), .wr_b_im_o (wr_b_im_o)
  );

  typedef struct packed {
    logic [1:0]  st;
    logic [2:0]  tw;
    logic [15:0] rar, rai, rbr, rbi, war, wai, wbr, wbi;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  int    checks = 0;
  int    failures = 0;
  logic  prev_busy = 1'b0;
  bit    finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rev(int i, int lg);
    int r = 0;
    for (int b = 0; b < lg; b++) if ((i >> b) & 1) r |= 1 << (lg - 1 - b);
    return r;
  endfunction

  // Push the expected butterflies of one run, built block by block
  task automatic push_run(input bit big, input logic [15:0] src, input logic [15:0] dst);
    int lg = big ? 4 : 3;
    int n  = 1 << lg;
    item_t it;
    for (int s = 0; s < lg; s++) begin
      int half = 1 << s;
      for (int blk = 0; blk < n; blk += 2 * half) begin
        for (int j = 0; j < half; j++) begin
          int p = blk + j;
          int q = p + half;
          logic [15:0] rb;
          int rp, rq;
          rb = (s == 0) ? src : dst;
          rp = (s == 0) ? rev(p, lg) : p;
          rq = (s == 0) ? rev(q, lg) : q;
          it.st  = 2'(s);
          it.tw  = 3'(j * (n / (2 * half)));
          it.rar = rb + 16'(2 * rp);
          it.rai = rb + 16'(2 * rp + 1);
          it.rbr = rb + 16'(2 * rq);
          it.rbi = rb + 16'(2 * rq + 1);
          it.war = dst + 16'(2 * p);
          it.wai = dst + 16'(2 * p + 1);
          it.wbr = dst + 16'(2 * q);
          it.wbi = dst + 16'(2 * q + 1);
          exp_q.push_back(it);
        end
      end
    end
  endtask

  // Monitor: pop and compare each presented butterfly
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) begin
        if (exp_q.size() == 0) begin
          chk("R2 extra busy cycle", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          chk("R3 stage", stage_o, cur.st);
          chk("R7 twiddle", twiddle_o, cur.tw);
          if (cur.st == 0) begin
            chk("R4 rd_a_re", rd_a_re_o, cur.rar);
            chk("R4 rd_b_re", rd_b_re_o, cur.rbr);
          end else begin
            chk("R5 rd_a_re", rd_a_re_o, cur.rar);
            chk("R5 rd_b_re", rd_b_re_o, cur.rbr);
          end
          chk("R6 rd_a_im", rd_a_im_o, cur.rai);
          chk("R6 rd_b_im", rd_b_im_o, cur.rbi);
          chk("R3 wr_a_re", wr_a_re_o, cur.war);
          chk("R3 wr_b_re", wr_b_re_o, cur.wbr);
          chk("R6 wr_a_im", wr_a_im_o, cur.wai);
          chk("R6 wr_b_im", wr_b_im_o, cur.wbi);
        end
      end
      if (done_o) chk("R8 done after last, busy low", {prev_busy, busy_o}, 2'b10);
      else if (prev_busy && !busy_o) chk("R8 missing done", 0, 1);
      prev_busy = busy_o;
    end
  end

  // Driver: one run; b2b starts in the current (done) cycle; noise toggles inputs while busy
  task automatic run(input bit big, input logic [15:0] src, input logic [15:0] dst,
                     input bit b2b, input bit noise);
    int cnt = 0;
    int it  = 0;
    push_run(big, src, dst);
    if (!b2b) @(negedge clk);
    start_i = 1'b1; size16_i = big; src_base_i = src; dst_base_i = dst;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && it < 100) begin
      if (busy_o) cnt++;
      if (noise && it < 4) begin
        start_i = 1'b1; size16_i = ~big;
        src_base_i = 16'h5A5A ^ 16'(it); dst_base_i = 16'hA5A5 + 16'(it);
      end else begin
        start_i = 1'b0;
      end
      it++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(noise ? "R9 busy cycles with start noise" : "R2 busy cycles", cnt, big ? 32 : 12);
    chk("R2 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 done after reset", done_o, 0);

    run(1'b0, 16'h0100, 16'h0200, 1'b0, 1'b0);
    run(1'b1, 16'h1000, 16'h2000, 1'b0, 1'b0);
    run(1'b1, 16'h7FFC, 16'hFFF0, 1'b0, 1'b0);   // R6 wrap
    run(1'b0, 16'h0040, 16'h0080, 1'b0, 1'b1);   // R9 noise
    @(negedge clk);
    chk("R9 idle after noisy run", busy_o, 0);
    run(1'b1, 16'h0300, 16'h0400, 1'b0, 1'b0);
    run(1'b0, 16'h0500, 16'h0600, 1'b1, 1'b0);   // R10 back to back
    @(negedge clk);
    chk("R10 idle after back-to-back pair", busy_o, 0);
    chk("R8 single done pulse", done_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule